// File: doc/BRIEF.md
# Flag Bank Exchange Unit

This unit executes one instruction that treats a 32-bit register as a bank of sixteen saved carry/zero flag pairs. In one operation it moves one chosen pair into the live carry and zero flags and stores the current live flags into another chosen pair. Both indices are random access, so there is no shifting through the bank.

A 9-bit selector supplies both indices. The low nibble is the read index. The next four bits are the write index, and the top bit suppresses the write. Setting the top bit therefore turns any write address of 16 or above into a discard of the current flags. Separate enables decide whether the live carry and the live zero flag take the value read from the bank.

The logic is combinational. A single output register samples it on a valid strobe, so each operation produces its result one cycle later.

Top module: `flag_bank_xchg`

## Requirements
- R1: While rst_ni is low, and after reset until the first valid operation, valid_o, reg_o, c_o, z_o and reg_we_o are all 0.
- R2: Pair n lives in register bits [2n+1:2n], with C at bit 2n+1 and Z at bit 2n. The read index is sel_i[3:0]. When upd_c_i is 1, c_o equals reg_i[2r+1]. When upd_z_i is 1, z_o equals reg_i[2r].
- R3: When sel_i[8] is 0, reg_o equals reg_i with bits [2w+1:2w] replaced by {c_i, z_i}, where w is sel_i[7:4]. All other bits are unchanged and reg_we_o is 1.
- R4: When sel_i[8] is 1, reg_o equals reg_i and reg_we_o is 0, whatever the value of sel_i[7:4].
- R5: When upd_c_i is 0, c_o equals c_i. When upd_z_i is 0, z_o equals z_i.
- R6: The read uses the register value from before the write. When the read and write indices are equal, the outputs swap the stored pair with the live flags.
- R7: The results of an operation presented with valid_i high appear on the outputs one cycle later, with valid_o high for exactly that cycle. While valid_i is low, reg_o, c_o, z_o and reg_we_o hold their values and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| reg_i | input | 32 | Flag bank register value |
| sel_i | input | 9 | Selector: [3:0] read index, [7:4] write index, [8] write suppress |
| c_i | input | 1 | Live carry flag |
| z_i | input | 1 | Live zero flag |
| upd_c_i | input | 1 | Load carry from the selected pair |
| upd_z_i | input | 1 | Load zero from the selected pair |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| reg_o | output | 32 | Updated register value |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| reg_we_o | output | 1 | Register write-back enable |

## Verification
The assertions compare each output with the inputs sampled one cycle earlier. For this to be sound, the inputs must be stable across the capturing clock edge and valid_i must be 0 during reset. The bench drives every input on the falling edge and holds valid_i low until reset is released. Each vector is held for one rising edge only, so the $past-based checks always look at the vector that was actually captured.

// File: rtl/flag_bank_pkg.sv
package flag_bank_pkg;
  localparam int unsigned NUM_PAIRS = 16;
  localparam int unsigned IDX_W     = $clog2(NUM_PAIRS);
  localparam int unsigned REG_W     = 2 * NUM_PAIRS;
  localparam int unsigned SEL_W     = 2 * IDX_W + 1;
endpackage

// File: rtl/flag_pair_read.sv
module flag_pair_read #(
  parameter int unsigned N_PAIRS = 16,
  parameter int unsigned IDX_W   = $clog2(N_PAIRS)
) (
  input  logic [2*N_PAIRS-1:0] bank_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic                 c_o,
  output logic                 z_o
);
  logic [N_PAIRS-1:0] c_vec, z_vec;

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_split
    assign c_vec[i] = bank_i[2*i+1];
    assign z_vec[i] = bank_i[2*i];
  end

  assign c_o = c_vec[idx_i];
  assign z_o = z_vec[idx_i];
endmodule

// File: rtl/flag_pair_write.sv
module flag_pair_write #(
  parameter int unsigned N_PAIRS = 16,
  parameter int unsigned IDX_W   = $clog2(N_PAIRS)
) (
  input  logic [2*N_PAIRS-1:0] bank_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 en_i,
  input  logic                 c_i,
  input  logic                 z_i,
  output logic [2*N_PAIRS-1:0] bank_o
);
  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    logic hit;
    assign hit           = en_i && (idx_i == IDX_W'(i));
    assign bank_o[2*i+1] = hit ? c_i : bank_i[2*i+1];
    assign bank_o[2*i]   = hit ? z_i : bank_i[2*i];
  end
endmodule

// File: rtl/flag_out_stage.sv
module flag_out_stage #(
  parameter int unsigned W = 35
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/flag_bank_xchg.sv
module flag_bank_xchg
  import flag_bank_pkg::*;
#(
  parameter int unsigned N_PAIRS = NUM_PAIRS,
  localparam int unsigned IW     = $clog2(N_PAIRS),
  localparam int unsigned RW     = 2 * N_PAIRS,
  localparam int unsigned SW     = 2 * IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [RW-1:0] reg_i,
  input  logic [SW-1:0] sel_i,
  input  logic          c_i,
  input  logic          z_i,
  input  logic          upd_c_i,
  input  logic          upd_z_i,
  output logic          valid_o,
  output logic [RW-1:0] reg_o,
  output logic          c_o,
  output logic          z_o,
  output logic          reg_we_o
);
  logic [IW-1:0] rd_idx, wr_idx;
  logic          wr_en;
  logic          rd_c, rd_z;
  logic [RW-1:0] bank_nxt;
  logic          c_nxt, z_nxt;

  assign rd_idx = sel_i[IW-1:0];
  assign wr_idx = sel_i[2*IW-1:IW];
  assign wr_en  = ~sel_i[2*IW];

  // read taps the incoming bank so an equal-index op is a swap
  flag_pair_read #(.N_PAIRS(N_PAIRS), .IDX_W(IW)) rd_i (
    .bank_i(reg_i), .idx_i(rd_idx), .c_o(rd_c), .z_o(rd_z)
  );

  flag_pair_write #(.N_PAIRS(N_PAIRS), .IDX_W(IW)) wr_i (
    .bank_i(reg_i), .idx_i(wr_idx), .en_i(wr_en),
    .c_i(c_i), .z_i(z_i), .bank_o(bank_nxt)
  );

  assign c_nxt = upd_c_i ? rd_c : c_i;
  assign z_nxt = upd_z_i ? rd_z : z_i;

  flag_out_stage #(.W(RW + 3)) out_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .d_i    ({wr_en, c_nxt, z_nxt, bank_nxt}),
    .valid_o(valid_o),
    .q_o    ({reg_we_o, c_o, z_o, reg_o})
  );
endmodule

// File: rtl/flag_bank_xchg_chk.sv
module flag_bank_xchg_chk #(
  parameter int unsigned RW = 32,
  parameter int unsigned SW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [RW-1:0] reg_i,
  input logic [SW-1:0] sel_i,
  input logic          c_i,
  input logic          z_i,
  input logic          upd_c_i,
  input logic          upd_z_i,
  input logic          valid_o,
  input logic [RW-1:0] reg_o,
  input logic          c_o,
  input logic          z_o,
  input logic          reg_we_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(reg_o) && $stable(c_o) && $stable(z_o) && $stable(reg_we_o)); // R7
  AST_WE_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> reg_we_o == !$past(sel_i[SW-1])); // R3
  AST_DISCARD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sel_i[SW-1] |=> reg_o == $past(reg_i)); // R4
  AST_WRITE_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> $countones(reg_o ^ $past(reg_i)) <= 2); // R3
  AST_C_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !upd_c_i |=> c_o == $past(c_i)); // R5
  AST_Z_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !upd_z_i |=> z_o == $past(z_i)); // R5
endmodule

bind flag_bank_xchg flag_bank_xchg_chk #(.RW(RW), .SW(SW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .reg_i(reg_i),
  .sel_i(sel_i), .c_i(c_i), .z_i(z_i), .upd_c_i(upd_c_i), .upd_z_i(upd_z_i),
  .valid_o(valid_o), .reg_o(reg_o), .c_o(c_o), .z_o(z_o), .reg_we_o(reg_we_o)
);

// File: tb/flag_bank_xchg_tb.sv
module flag_bank_xchg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] regv = '0;
  logic [8:0]  sel = '0;
  logic        c = 1'b0, z = 1'b0, uc = 1'b0, uz = 1'b0;
  logic        valid_o, c_o, z_o, we_o;
  logic [31:0] reg_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  flag_bank_xchg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .reg_i(regv), .sel_i(sel),
    .c_i(c), .z_i(z), .upd_c_i(uc), .upd_z_i(uz),
    .valid_o(valid_o), .reg_o(reg_o), .c_o(c_o), .z_o(z_o), .reg_we_o(we_o)
  );

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural model: returns {valid, we, c, z, reg}
  function automatic logic [35:0] model(logic [31:0] r, logic [8:0] s,
                                        logic ci, logic zi, logic u_c, logic u_z);
    int          rd = int'(s[3:0]);
    int          wr = int'(s[7:4]);
    logic [31:0] nr = r;
    logic        nc = ci, nz = zi;
    if (u_c) nc = r[2*rd+1];
    if (u_z) nz = r[2*rd];
    if (!s[8]) begin
      nr[2*wr+1] = ci;
      nr[2*wr]   = zi;
    end
    return {1'b1, !s[8], nc, nz, nr};
  endfunction

  task automatic apply(string tag, logic [31:0] r, logic [8:0] s,
                       logic ci, logic zi, logic u_c, logic u_z);
    logic [35:0] e;
    @(negedge clk);
    regv = r; sel = s; c = ci; z = zi; uc = u_c; uz = u_z; valid = 1'b1;
    e = model(r, s, ci, zi, u_c, u_z);
    @(negedge clk);
    valid = 1'b0;
    chk(tag, {valid_o, we_o, c_o, z_o, reg_o}, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] last;
    #23;
    chk("R1 in reset", {valid_o, we_o, c_o, z_o, reg_o}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {valid_o, we_o, c_o, z_o, reg_o}, '0);

    apply("R3 R2 sel 0x01 upd c", 32'h0000_0008, 9'h001, 1'b0, 1'b1, 1'b1, 1'b0);
    apply("R3 R2 sel 0xC4 upd z", 32'h0000_0100, 9'h0C4, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R4 R2 sel 0x107 both", 32'h0000_8000, 9'h107, 1'b0, 1'b1, 1'b1, 1'b1);
    apply("R3 R5 sel 0x88 none", 32'hFFFF_FFFF, 9'h088, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R6 swap idx 5", 32'h0000_0800, 9'h055, 1'b0, 1'b1, 1'b1, 1'b1);
    apply("R6 swap idx 15", 32'h4000_0000, 9'h0FF, 1'b1, 1'b1, 1'b1, 1'b1);
    apply("R4 discard 0x1F3", 32'hA5A5_5A5A, 9'h1F3, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R5 flags hold", 32'h0000_0000, 9'h1AA, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 write pair 15", 32'h0000_0000, 9'h0F0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R2 read pair 0", 32'h0000_0003, 9'h1F0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R7 idle hold: change inputs with valid low, outputs must not move
    last = {1'b0, we_o, c_o, z_o, reg_o};
    @(negedge clk);
    regv = 32'h1234_5678; sel = 9'h012; c = 1'b0; z = 1'b1; uc = 1'b1; uz = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 idle hold", {valid_o, we_o, c_o, z_o, reg_o}, last);

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] s = 9'($urandom);
      apply("R2 R3 R4 R5 R6 random", $urandom, s, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule